// File: doc/BRIEF.md
# Paged Byte-Wide EEPROM Write Controller

This block is a clock-driven model of the control side of a parallel, byte-wide electrically erasable memory that programs a whole page at a time. A host reaches it through active-low chip-enable, output-enable, write-enable and program-reset pins, plus an address bus and split data-in and data-out buses. The memory has an array of bytes, and each page holds 64 of them. A load cycle stores one byte into a page buffer. Loads keep arriving while each follows the previous one within a load window. When the window runs out, the block enters a self-timed programming phase and copies the loaded bytes of that page into the array.

While programming runs, the block pulls an open-drain ready/busy indication low. A read during this phase returns a polling word instead of array data. In that word the top data bit is the inverse of bit 7 of the last byte loaded. A low level on the program-reset pin stops any programming and floats the outputs. The load window and the programming time are given in clock cycles by parameters. The address width is a parameter too: a full 8K by 8 part uses 13 address bits, and the default is smaller so that elaboration stays light.

Top module: `eep_page_writer`

## Requirements
- R1: The low 6 address bits pick the byte within a page and the upper bits pick the page. When a page with all 64 bytes loaded has been programmed, reading each address returns the byte loaded there.
- R2: The first load after idle sets the page. Later loads in the same burst use only their low 6 address bits and ignore their page bits.
- R3: A load occurs on the first clock in which ceN=0, weN=0, oeN=1 and resN=1 after a clock in which that was not so. If no further load follows, rdyBusyLow rises exactly LOAD_WIN clocks after the clock of the last load.
- R4: rdyBusyLow stays high for max(PROG_CYC, 64) clocks and then returns low. It is low after reset and whenever the block is idle or loading.
- R5: During programming, a read returns a word whose bit 7 is the inverse of bit 7 of the last loaded byte, with bits 6..0 at zero. After programming ends, the same read returns the array data.
- R6: When a page is programmed, any byte of it that was not loaded keeps its previous array contents.
- R7: Load attempts made while rdyBusyLow is high are ignored and change no array byte.
- R8: No load occurs while ceN is high, while oeN is low, or while weN is high. Such an attempt in idle starts no programming.
- R9: While resN is low, programming and any pending loads are dropped, and from the next clock rdyBusyLow and dataDrive are low. Bytes loaded before the abort, whose window had not yet run out, are never written.
- R10: A read with ceN=0, oeN=0, weN=1 and resN=1 gives dataDrive=1 and the data one clock later. dataDrive is 0 in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous system reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| resN | input | 1 | Program reset, active low |
| addr | input | ADDR_W | Byte address; low 6 bits are the in-page offset |
| dataIn | input | 8 | Data for byte loads |
| dataOut | output | 8 | Read data or polling word |
| dataDrive | output | 1 | High when dataOut is driven |
| rdyBusyLow | output | 1 | High while the ready/busy pin is pulled low (programming) |

## Verification
The bench builds the block with ADDR_W=8, LOAD_WIN=16 and PROG_CYC=80. That gives four pages, a load window short enough that the exact clock of the busy rise can be counted, and a programming phase just longer than the 64-step commit. With these values, whole-page writes, bursts that jump pages, polling reads during programming and aborts both before and after the busy rise all fit in a few thousand clocks. Because there are only four pages, every byte the bench reads back has been written beforehand.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } eepState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchPage;   // first load of a burst: capture page bits
    logic loadByte;    // store dataIn into the page buffer
    logic commitStep;  // copy one buffer slot into the array
    logic clearBuf;    // forget loaded bytes
    logic busy;        // programming phase active
  } ctrlStrobe_t;

endpackage

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int LOAD_WIN   = 16,
  parameter int PROG_CYC   = 80,
  parameter int PAGE_BYTES = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceN,
  input  logic        oeN,
  input  logic        weN,
  input  logic        resN,
  output ctrlStrobe_t strb
);

  localparam int PROG_LEN = (PROG_CYC > PAGE_BYTES) ? PROG_CYC : PAGE_BYTES;
  localparam int LT_W     = $clog2(LOAD_WIN + 1);
  localparam int PT_W     = $clog2(PROG_LEN + 1);

  eepState_t       state;
  logic [LT_W-1:0] loadTimer;
  logic [PT_W-1:0] progTimer;
  logic            wrPrev;
  logic            wrNow;
  logic            loadHit;
  logic            progLast;

  assign wrNow    = !ceN && !weN && oeN && resN;
  assign loadHit  = wrNow && !wrPrev && (state != ST_PROG);
  assign progLast = (state == ST_PROG) && (progTimer == PT_W'(PROG_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPrev <= 1'b0;
    end else begin
      wrPrev <= wrNow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !resN) begin
      state     <= ST_IDLE;
      loadTimer <= '0;
      progTimer <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          loadTimer <= '0;
          progTimer <= '0;
          if (loadHit) state <= ST_LOAD;
        end
        ST_LOAD: begin
          if (loadHit) begin
            loadTimer <= '0;
          end else if (loadTimer == LT_W'(LOAD_WIN - 1)) begin
            state     <= ST_PROG;
            loadTimer <= '0;
            progTimer <= '0;
          end else begin
            loadTimer <= loadTimer + 1'b1;
          end
        end
        ST_PROG: begin
          if (progLast) begin
            state     <= ST_IDLE;
            progTimer <= '0;
          end else begin
            progTimer <= progTimer + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.latchPage  = loadHit && (state == ST_IDLE);
    strb.loadByte   = loadHit;
    strb.commitStep = (state == ST_PROG) && (progTimer < PT_W'(PAGE_BYTES));
    strb.clearBuf   = !resN || progLast;
    strb.busy       = (state == ST_PROG);
  end

endmodule

// File: rtl/eep_datapath.sv
module eep_datapath
  import eep_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              resN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  ctrlStrobe_t       strb,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataDrive
);

  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PGSEL_W    = ADDR_W - PAGE_W;

  logic [DATA_W-1:0]     memArr  [DEPTH];
  logic [DATA_W-1:0]     pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] loadMask;
  logic [PGSEL_W-1:0]    pageReg;
  logic [PAGE_W-1:0]     commitIdx;
  logic                  lastMsb;
  logic                  readEn;
  logic [PAGE_W-1:0]     offs;

  assign readEn = !ceN && !oeN && weN && resN;
  assign offs   = addr[PAGE_W-1:0];

  // storage without reset: buffer, array, read port
  always_ff @(posedge clk) begin
    if (strb.loadByte) pageBuf[offs] <= dataIn;
    if (strb.commitStep && loadMask[commitIdx])
      memArr[{pageReg, commitIdx}] <= pageBuf[commitIdx];
    if (strb.busy) dataOut <= {~lastMsb, {(DATA_W-1){1'b0}}};
    else           dataOut <= memArr[addr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadMask  <= '0;
      pageReg   <= '0;
      commitIdx <= '0;
      lastMsb   <= 1'b0;
      dataDrive <= 1'b0;
    end else begin
      dataDrive <= readEn;
      if (strb.clearBuf) begin
        loadMask  <= '0;
        commitIdx <= '0;
      end else begin
        if (strb.latchPage) begin
          pageReg   <= addr[ADDR_W-1:PAGE_W];
          commitIdx <= '0;
        end
        if (strb.loadByte) begin
          loadMask[offs] <= 1'b1;
          lastMsb        <= dataIn[DATA_W-1];
        end
        if (strb.commitStep) commitIdx <= commitIdx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/eep_page_writer.sv
module eep_page_writer
  import eep_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int LOAD_WIN = 16,
  parameter int PROG_CYC = 80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              resN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataDrive,
  output logic              rdyBusyLow
);

  localparam int DATA_W     = 8;
  localparam int PAGE_W     = 6;
  localparam int PAGE_BYTES = 1 << PAGE_W;

  ctrlStrobe_t strb;

  eep_ctrl #(
    .LOAD_WIN  (LOAD_WIN),
    .PROG_CYC  (PROG_CYC),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_ctrl (
    .clk (clk),
    .rstN(rstN),
    .ceN (ceN),
    .oeN (oeN),
    .weN (weN),
    .resN(resN),
    .strb(strb)
  );

  eep_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .PAGE_W(PAGE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ceN      (ceN),
    .oeN      (oeN),
    .weN      (weN),
    .resN     (resN),
    .addr     (addr),
    .dataIn   (dataIn),
    .strb     (strb),
    .dataOut  (dataOut),
    .dataDrive(dataDrive)
  );

  assign rdyBusyLow = strb.busy;

endmodule

// File: rtl/eep_page_writer_chk.sv
module eep_page_writer_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              oeN,
  input logic              weN,
  input logic              resN,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataDrive,
  input logic              rdyBusyLow
);

  // R9
  abort_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resN |=> (!rdyBusyLow && !dataDrive));

  // R10
  drive_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataDrive |-> $past(!ceN && !oeN && weN && resN));

  // R10
  drive_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !oeN && weN && resN) |=> dataDrive);

  // R5
  poll_low_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataDrive && $past(rdyBusyLow)) |-> (dataOut[DATA_W-2:0] == '0));

  // R4
  busy_min_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rdyBusyLow) && resN) |=> rdyBusyLow);

endmodule

bind eep_page_writer eep_page_writer_chk #(.DATA_W(8)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ceN       (ceN),
  .oeN       (oeN),
  .weN       (weN),
  .resN      (resN),
  .dataOut   (dataOut),
  .dataDrive (dataDrive),
  .rdyBusyLow(rdyBusyLow)
);

// File: tb/eep_page_writer_bench.sv
module eep_page_writer_bench;

  localparam int AW = 8;
  localparam int LW = 16;
  localparam int PC = 80;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ceN = 1'b1, oeN = 1'b1, weN = 1'b1, resN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    dataIn = '0;
  logic [7:0]    dataOut;
  logic          dataDrive, rdyBusyLow;

  int total = 0;
  int bad   = 0;

  logic [7:0] expQ  [$];
  logic [7:0] maskQ [$];
  string      tagQ  [$];

  eep_page_writer #(.ADDR_W(AW), .LOAD_WIN(LW), .PROG_CYC(PC)) u_eep_page_writer (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .resN(resN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataDrive(dataDrive),
    .rdyBusyLow(rdyBusyLow)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares every driven read word against the queue
  always @(negedge clk) begin
    if (rstN && dataDrive) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R10 unexpected drive", dataOut, 0);
      end else begin
        logic [7:0] e, m;
        string t;
        e = expQ.pop_front();
        m = maskQ.pop_front();
        t = tagQ.pop_front();
        chk((dataOut & m) === (e & m), t, dataOut, e);
      end
    end
  end

  task automatic loadByte(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    ceN = 1'b0; weN = 1'b0; oeN = 1'b1; addr = a; dataIn = d;
    @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
  endtask

  task automatic readExp(input logic [AW-1:0] a, input logic [7:0] e,
                         input logic [7:0] m, input string tag);
    @(negedge clk);
    ceN = 1'b0; oeN = 1'b0; weN = 1'b1; addr = a;
    expQ.push_back(e); maskQ.push_back(m); tagQ.push_back(tag);
    @(negedge clk);
    ceN = 1'b1; oeN = 1'b1;
    @(negedge clk);
  endtask

  task automatic waitIdle();
    int n = 0;
    while (!rdyBusyLow && n < 500) begin @(negedge clk); n++; end
    while (rdyBusyLow && n < 1000) begin @(negedge clk); n++; end
    chk(n < 1000, "R4 programming ends", n, 0);
  endtask

  task automatic loadPage(input int pg, input logic [7:0] base);
    for (int i = 0; i < 64; i++) loadByte(AW'(pg * 64 + i), base ^ 8'(i));
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(rdyBusyLow == 1'b0, "R4 idle after reset", rdyBusyLow, 0);
    chk(dataDrive == 1'b0, "R10 no drive after reset", dataDrive, 0);

    // R3/R4: exact busy timing on page 0
    for (int i = 0; i < 64; i++) loadByte(AW'(i), 8'(i * 7 + 1));
    repeat (LW - 1) @(negedge clk);
    chk(rdyBusyLow == 1'b0, "R3 not busy before window end", rdyBusyLow, 0);
    @(negedge clk);
    chk(rdyBusyLow == 1'b1, "R3 busy at window end", rdyBusyLow, 1);
    repeat (PC - 1) @(negedge clk);
    chk(rdyBusyLow == 1'b1, "R4 busy at last cycle", rdyBusyLow, 1);
    @(negedge clk);
    chk(rdyBusyLow == 1'b0, "R4 released", rdyBusyLow, 0);
    for (int i = 0; i < 64; i++) readExp(AW'(i), 8'(i * 7 + 1), 8'hFF, "R1 page readback");

    // fill pages 1..3
    loadPage(1, 8'hA0); waitIdle();
    loadPage(2, 8'h40); waitIdle();
    loadPage(3, 8'h11); waitIdle();

    // R2/R5/R6/R7: partial burst jumping page bits
    loadByte(AW'(64 + 5), 8'h33);
    loadByte(AW'(128 + 9), 8'h7C);
    while (!rdyBusyLow) @(negedge clk);
    readExp(AW'(64 + 5), 8'h80, 8'hFF, "R5 polling word");
    loadByte(AW'(64 + 20), 8'h55);
    waitIdle();
    readExp(AW'(64 + 5), 8'h33, 8'hFF, "R1 loaded byte");
    readExp(AW'(64 + 9), 8'h7C, 8'hFF, "R2 page bits ignored, R5 true data");
    readExp(AW'(128 + 9), 8'h40 ^ 8'd9, 8'hFF, "R2 other page untouched");
    readExp(AW'(64 + 6), 8'hA0 ^ 8'd6, 8'hFF, "R6 unloaded byte kept");
    readExp(AW'(64 + 20), 8'hA0 ^ 8'd20, 8'hFF, "R7 load while busy ignored");

    // R8: inhibited writes
    @(negedge clk); ceN = 1'b0; weN = 1'b0; oeN = 1'b0; addr = AW'(192); dataIn = 8'hFE;
    @(negedge clk); ceN = 1'b1; weN = 1'b1; oeN = 1'b1;
    @(negedge clk); ceN = 1'b1; weN = 1'b0; addr = AW'(192);
    @(negedge clk); weN = 1'b1;
    @(negedge clk); ceN = 1'b0; weN = 1'b1; oeN = 1'b1;
    @(negedge clk); ceN = 1'b1;
    repeat (LW + 4) @(negedge clk);
    chk(rdyBusyLow == 1'b0, "R8 inhibited write starts nothing", rdyBusyLow, 0);
    readExp(AW'(192), 8'h11, 8'hFF, "R8 array unchanged");

    // R9: abort during load window
    loadByte(AW'(193), 8'hEE);
    @(negedge clk); resN = 1'b0;
    @(negedge clk);
    chk(rdyBusyLow == 1'b0, "R9 idle while reset", rdyBusyLow, 0);
    resN = 1'b1;
    repeat (LW + 4) @(negedge clk);
    chk(rdyBusyLow == 1'b0, "R9 aborted load not programmed", rdyBusyLow, 0);
    readExp(AW'(193), 8'h11 ^ 8'd1, 8'hFF, "R9 aborted byte not written");

    // R9: abort during programming, with a read attempted
    loadByte(AW'(194), 8'h5A);
    while (!rdyBusyLow) @(negedge clk);
    resN = 1'b0; ceN = 1'b0; oeN = 1'b0; weN = 1'b1;
    @(negedge clk);
    chk(rdyBusyLow == 1'b0, "R9 busy dropped", rdyBusyLow, 0);
    chk(dataDrive == 1'b0, "R9 outputs float", dataDrive, 0);
    ceN = 1'b1; oeN = 1'b1;
    @(negedge clk);
    resN = 1'b1;
    repeat (LW + 4) @(negedge clk);
    chk(rdyBusyLow == 1'b0, "R9 stays idle after abort", rdyBusyLow, 0);

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R10 all reads answered", expQ.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule